// File: doc/BRIEF.md
# Debug Step Clock Controller

This block generates a clock-enable pulse stream for a user design under hardware debug. In normal mode it emits one pulse every `NOM_DIV` system-clock cycles, standing in for the nominal run clock, for example 200 Hz. A slide switch, after debouncing, moves the block into a slow debug mode. In that mode the pulses either come automatically at one of four low rates, or come one per press of a debounced push-button.

An LED output toggles on every debug-mode pulse, so single steps stay visible to the operator. The LED is dark whenever the normal mode is active. The user design qualifies its registers with `clk_en`, so no real clock multiplexing is needed.

A mode change is applied only in a cycle that carries no pulse, and it restarts the period counter. The pulse stream therefore never contains a truncated or doubled pulse at a switch-over.

Top module: `dbg_step_clock`

## Requirements
- R1: During and directly after reset, `clk_en` and `led` are 0 and the block is in normal mode.
- R2: In normal mode, `clk_en` pulses exactly once every `NOM_DIV` cycles.
- R3: In slow mode with `step_manual` = 0, the pulse period is chosen by `rate_sel`: 0 gives `RATE_100` cycles (100 Hz), 1 gives `RATE_10` (10 Hz), 2 gives `RATE_1` (1 Hz) and 3 gives `RATE_0P1` (0.1 Hz).
- R4: In slow mode with `step_manual` = 1, exactly one pulse follows each debounced rising edge of the button. No pulse occurs while the button is held, released or idle.
- R5: A raw input level is accepted only after it has been stable for `DEB_CYCLES` consecutive cycles. Shorter glitches on the switch or the button have no effect.
- R6: Every `clk_en` pulse is exactly one system-clock cycle wide.
- R7: In slow mode, `led` toggles in the same cycle as each pulse. In normal mode, `led` is 0.
- R8: A mode change is applied only in a cycle without a pulse. If a pulse and a mode change fall in the same cycle, the pulse is issued under the old mode and the change follows in the next cycle.
- R9: A change of `rate_sel` takes effect on the running count. If the count already exceeds the new period, a pulse is issued at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sw_raw | input | 1 | Raw mode switch, 1 = slow debug mode |
| step_btn_raw | input | 1 | Raw step push-button, 1 = pressed |
| step_manual | input | 1 | Slow-mode source, 1 = button, 0 = automatic |
| rate_sel | input | 2 | Automatic slow rate code (see R3) |
| clk_en | output | 1 | One-cycle clock-enable pulse |
| led | output | 1 | Step indicator drive |

## Verification
A debounced button edge and a debounced mode-switch edge can land in the same cycle. Both inputs share one debounce length, so raising the raw button and dropping the raw switch on the same cycle in manual slow mode makes their accepted edges coincide. The bench expects exactly one pulse in that window, with the LED toggled at that pulse and dark shortly after. It then expects normal-mode pulses to resume at the nominal period. An assertion also confirms that the applied mode never changes in a cycle that carries a pulse.

// File: rtl/dbgclk_pkg.sv
// Shared definitions for the debug step clock controller.
// Assumes: all periods are given in system-clock cycles.
package dbgclk_pkg;

    // Automatic slow-rate codes, fastest first.
    typedef enum logic [1:0] {
        RATE_C100  = 2'd0,
        RATE_C10   = 2'd1,
        RATE_C1    = 2'd2,
        RATE_C0P1  = 2'd3
    } rate_code_e;

    // Largest of four period values, used to size counters.
    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/dbgclk_debounce.sv
// Two-flop synchronizer followed by a stability filter.
// The output takes a new level only after the synchronized input has differed
// from it for STABLE_CYC consecutive cycles. Assumes STABLE_CYC >= 1.
module dbgclk_debounce #(
    parameter int unsigned STABLE_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic level
);
    localparam int CW = $clog2(STABLE_CYC + 1);

    logic          sync_a;
    logic          sync_b;
    logic [CW-1:0] run_cnt;

    // Bring the asynchronous input into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a <= 1'b0;
            sync_b <= 1'b0;
        end else begin
            sync_a <= raw;
            sync_b <= sync_a;
        end
    end

    // Count cycles of disagreement and accept the level once the count is full.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt <= '0;
            level   <= 1'b0;
        end else if (sync_b == level) begin
            run_cnt <= '0;
        end else if (run_cnt == CW'(STABLE_CYC - 1)) begin
            run_cnt <= '0;
            level   <= sync_b;
        end else begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dbgclk_divider.sv
// Free-running period counter with a live period input.
// tick is high in the last cycle of each period; a count at or above the last
// value also ticks, so a shortened period takes effect at once.
// Assumes period >= 2.
module dbgclk_divider #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic [CW-1:0] period,
    output logic          tick
);
    logic [CW-1:0] cnt;

    assign tick = (cnt >= period - 1'b1);

    // Advance the count, wrap on tick, restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n || clear || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/dbg_step_clock.sv
// Debug step clock controller: issues one-cycle clock-enable pulses at the
// nominal period in normal mode, or in slow mode at a selected low rate or once
// per debounced button press. The LED toggles on each slow pulse.
// Assumes all periods >= 2 and that step_manual and rate_sel are synchronous.
module dbg_step_clock #(
    parameter int unsigned DEB_CYCLES = 1000000,
    parameter int unsigned NOM_DIV    = 250000,
    parameter int unsigned RATE_100   = 500000,
    parameter int unsigned RATE_10    = 5000000,
    parameter int unsigned RATE_1     = 50000000,
    parameter int unsigned RATE_0P1   = 500000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_sw_raw,
    input  logic       step_btn_raw,
    input  logic       step_manual,
    input  logic [1:0] rate_sel,
    output logic       clk_en,
    output logic       led
);
    import dbgclk_pkg::*;

    localparam int unsigned MAX_PER = max4(max4(RATE_100, RATE_10, RATE_1, RATE_0P1),
                                           NOM_DIV, 2, 2);
    localparam int CW = $clog2(MAX_PER + 1);

    logic          mode_db;
    logic          step_db;
    logic          step_prev;
    logic          step_rise;
    logic          slow_q;
    logic [CW-1:0] rate_per;
    logic [CW-1:0] period;
    logic          tick;
    logic          cand;
    logic          apply_sw;
    logic          div_clear;

    dbgclk_debounce #(.STABLE_CYC(DEB_CYCLES)) u_mode_db (
        .clk(clk), .rst_n(rst_n), .raw(mode_sw_raw), .level(mode_db)
    );

    dbgclk_debounce #(.STABLE_CYC(DEB_CYCLES)) u_step_db (
        .clk(clk), .rst_n(rst_n), .raw(step_btn_raw), .level(step_db)
    );

    // Remember the previous debounced button level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) step_prev <= 1'b0;
        else        step_prev <= step_db;
    end

    assign step_rise = step_db & ~step_prev;

    // Map the rate code onto its period.
    always_comb begin
        unique case (rate_code_e'(rate_sel))
            RATE_C100: rate_per = CW'(RATE_100);
            RATE_C10:  rate_per = CW'(RATE_10);
            RATE_C1:   rate_per = CW'(RATE_1);
            default:   rate_per = CW'(RATE_0P1);
        endcase
    end

    assign period    = slow_q ? rate_per : CW'(NOM_DIV);
    assign cand      = (slow_q && step_manual) ? step_rise : tick;
    assign apply_sw  = (mode_db != slow_q) && !cand;
    assign div_clear = apply_sw || (slow_q && step_manual);

    dbgclk_divider #(.CW(CW)) u_div (
        .clk(clk), .rst_n(rst_n), .clear(div_clear), .period(period), .tick(tick)
    );

    // Apply a pending mode change only in a cycle without a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        slow_q <= 1'b0;
        else if (apply_sw) slow_q <= mode_db;
    end

    // Register the enable pulse and the step indicator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_en <= 1'b0;
            led    <= 1'b0;
        end else begin
            clk_en <= cand;
            if (!slow_q)   led <= 1'b0;
            else if (cand) led <= ~led;
        end
    end

endmodule

// File: rtl/dbgclk_checker.sv
// Temporal checks for dbg_step_clock, attached with bind.
// Assumes the periods configured on the top are at least 2.
module dbgclk_checker (
    input logic clk,
    input logic rst_n,
    input logic clk_en,
    input logic led,
    input logic slow_q,
    input logic manual,
    input logic step_rise
);
    // R6: a pulse never lasts two cycles.
    assert_pulse_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en |=> !clk_en);

    // R7: the indicator stays dark through normal mode.
    assert_led_dark_normal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!slow_q && !$past(slow_q)) |-> !led);

    // R7: the indicator moves only with a pulse or when cleared.
    assert_led_with_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (led != $past(led)) |-> (clk_en || !led));

    // R4: in manual slow mode, every pulse follows an accepted press edge.
    assert_manual_press_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && $past(slow_q && manual)) |-> $past(step_rise));

    // R8: the applied mode never changes in a cycle carrying a pulse.
    assert_switch_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slow_q != $past(slow_q)) |-> !clk_en);

endmodule

bind dbg_step_clock dbgclk_checker u_chk (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .led(led),
    .slow_q(slow_q), .manual(step_manual), .step_rise(step_rise)
);

// File: tb/sim_dbg_step_clock.sv
// Scoreboard bench: drivers queue expected pulse intervals, a monitor compares.
module sim_dbg_step_clock;
    localparam int DEB = 6;
    localparam int NOM = 16;
    localparam int P0 = 6, P1 = 9, P2 = 12, P3 = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_sw_raw = 1'b0;
    logic step_btn_raw = 1'b0;
    logic step_manual = 1'b0;
    logic [1:0] rate_sel = 2'd0;
    logic clk_en;
    logic led;

    typedef struct { int per; string tag; } exp_t;
    exp_t exp_q[$];

    int checks = 0, errors = 0;
    int cyc = 0, last_cyc = 0, pulses = 0;
    bit have_last = 0, prev_en = 0, wide_seen = 0;
    logic led_at_pulse = 1'b0;
    bit done = 0;

    dbg_step_clock #(.DEB_CYCLES(DEB), .NOM_DIV(NOM), .RATE_100(P0), .RATE_10(P1),
                     .RATE_1(P2), .RATE_0P1(P3)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_sw_raw(mode_sw_raw), .step_btn_raw(step_btn_raw),
        .step_manual(step_manual), .rate_sel(rate_sel), .clk_en(clk_en), .led(led)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: counts pulses, compares intervals against the queue.
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (clk_en) begin
                pulses++;
                led_at_pulse = led;
                if (prev_en) wide_seen = 1;
                if (have_last && exp_q.size() > 0) begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(cyc - last_cyc == e.per, e.tag, cyc - last_cyc, e.per);
                end
                last_cyc  = cyc;
                have_last = 1;
            end
            prev_en = clk_en;
        end
    end

    // Driver: sync to a pulse, then queue n expected intervals and wait for them.
    task automatic arm(input int per, input int n, input string tag);
        @(negedge clk iff clk_en);
        @(posedge clk);
        for (int i = 0; i < n; i++) exp_q.push_back('{per, tag});
        wait (exp_q.size() == 0);
        @(posedge clk);
    endtask

    // Two consecutive pulses must show opposite indicator levels.
    task automatic led_toggle(input string tag);
        logic l1;
        @(negedge clk iff clk_en); #1 l1 = led_at_pulse;
        @(negedge clk iff clk_en); #1;
        check(led_at_pulse != l1, tag, led_at_pulse, !l1);
    endtask

    task automatic clear_count();
        @(posedge clk); pulses = 0;
    endtask

    task automatic wait_pos(input int n);
        repeat (n) @(posedge clk);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic l0;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(clk_en == 1'b0, "R1 clk_en in reset", clk_en, 0);
        check(led == 1'b0, "R1 led in reset", led, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check(clk_en == 1'b0 && led == 1'b0, "R1 after reset", {clk_en, led}, 0);

        // R2: normal period; R7: led dark
        arm(NOM, 3, "R2 normal period");
        check(led == 1'b0, "R7 led dark in normal", led, 0);

        // R5: short mode glitch is ignored
        @(negedge clk); mode_sw_raw = 1'b1;
        repeat (DEB - 3) @(negedge clk); mode_sw_raw = 1'b0;
        arm(NOM, 3, "R5 mode glitch ignored");

        // R3: automatic slow rates
        @(negedge clk); mode_sw_raw = 1'b1; rate_sel = 2'd0;
        wait_pos(40);
        arm(P0, 3, "R3 rate code 0");
        led_toggle("R7 led toggles per step");
        @(negedge clk); rate_sel = 2'd1; wait_pos(30);
        arm(P1, 3, "R3 rate code 1");
        @(negedge clk); rate_sel = 2'd2; wait_pos(30);
        arm(P2, 3, "R3 rate code 2");
        @(negedge clk); rate_sel = 2'd3; wait_pos(30);
        arm(P3, 3, "R3 rate code 3");

        // R9: shortening the period mid-count fires at once
        @(negedge clk iff clk_en);
        repeat (15) @(negedge clk);
        rate_sel = 2'd0;
        clear_count();
        wait_pos(6);
        check(pulses == 1, "R9 immediate pulse on shorter rate", pulses, 1);

        // R4: manual stepping
        @(negedge clk); step_manual = 1'b1;
        wait_pos(3);
        clear_count(); wait_pos(40);
        check(pulses == 0, "R4 no pulse while idle", pulses, 0);
        clear_count();
        @(negedge clk); step_btn_raw = 1'b1; wait_pos(40);
        check(pulses == 1, "R4 one pulse on held press", pulses, 1);
        @(negedge clk); step_btn_raw = 1'b0; wait_pos(40);
        check(pulses == 1, "R4 no pulse on release", pulses, 1);
        clear_count();
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); step_btn_raw = 1'b1; wait_pos(20);
            @(negedge clk); step_btn_raw = 1'b0; wait_pos(20);
        end
        check(pulses == 3, "R4 three presses", pulses, 3);

        // R5: short button glitch ignored
        clear_count();
        @(negedge clk); step_btn_raw = 1'b1;
        repeat (DEB - 3) @(negedge clk); step_btn_raw = 1'b0;
        wait_pos(30);
        check(pulses == 0, "R5 button glitch ignored", pulses, 0);

        // R8: press edge and mode edge in the same cycle
        @(posedge clk); l0 = led; pulses = 0;
        @(negedge clk); step_btn_raw = 1'b1; mode_sw_raw = 1'b0;
        wait_pos(14);
        check(pulses == 1, "R8 single pulse at coincident edges", pulses, 1);
        check(led_at_pulse == ~l0, "R8 pulse issued under slow mode", led_at_pulse, ~l0);
        check(led == 1'b0, "R7 led dark after switch", led, 0);
        @(negedge clk); step_btn_raw = 1'b0;
        arm(NOM, 2, "R8 normal resumes");

        // R6: no pulse ever wider than one cycle
        check(!wide_seen, "R6 one-cycle pulses", wide_seen, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule